// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the device side of a byte-wide parallel memory and turns a stream of bus write cycles (an address plus a data byte each) into operation requests. It follows the JEDEC-style software write protection scheme. No operation happens unless it is preceded by a two-write unlock at fixed command addresses. Erasing needs a second unlock after the erase setup byte. The decoder recognises five commands: byte program, sector erase, chip erase, identification entry and identification exit.

When a command completes, the decoder raises a single-cycle request together with the latched target address and data byte. These go to the program/erase engine. A status block drives a busy input, and while busy is high every write is thrown away.

A mode flag redirects reads to a small table of identification bytes. Outside that mode, reads return whatever the storage array presents. Any write that does not fit the sequence in progress sends the decoder back to plain read mode without raising a request.

Top module: `cmdseq_top`

## Requirements
- R1: A synchronous reset, active high, clears all requests, `op_addr`, `op_data`, `rd_data` and `id_mode`, and leaves the decoder waiting for the first unlock write. Identification mode therefore never outlives a reset.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any write W trigger a program. The cycle after W, `prog_req` is 1, `op_addr` equals W's address and `op_data` equals W's data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh followed by 30h at any address S trigger a sector erase. The cycle after that write, `sec_erase_req` is 1, `op_addr` holds S[18:12] with bits 11:0 zero, and `op_data` is 0.
- R4: The same five-write prefix as R3, followed by 10h@5555h, makes `chip_erase_req` 1 the following cycle, with `op_addr` and `op_data` both 0.
- R5: Command addresses are matched on address bits 14:0 only. Bits 18:15 have no effect on matching.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode` to 1 in the cycle after the third write.
- R7: `rd_data` is registered, so it reflects `rd_addr` and `id_mode` as they stood at the previous clock edge. In identification mode, offsets are taken from bits 14:0 of `rd_addr`: 0000h and 0003h return 7Fh, 0040h returns 1Fh, 0001h returns the `DEV_CODE` parameter (default B7h), and any other offset returns 00h. Outside identification mode, `rd_data` returns `arr_data`.
- R8: Identification mode is cleared the cycle after either of two exits, and both behave the same way. One exit is a lone F0h write at any address when no sequence is in progress. The other is AAh@5555h, 55h@2AAAh, F0h@5555h.
- R9: A write that does not match the next expected step aborts the sequence. The decoder returns to waiting for AAh@5555h, `id_mode` clears, and no request is raised. The aborting write is not itself taken as the first step of a new sequence. Completing a program or erase also clears `id_mode`.
- R10: A write made while `busy` is 1 is discarded. It neither advances nor resets the sequence and does not change `id_mode`.
- R11: Each request lasts exactly one cycle and at most one request is high in any cycle. Whenever no request is high, `op_addr` and `op_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Program/erase in progress; writes are discarded |
| rd_addr | input | 19 | Read address |
| arr_data | input | 8 | Byte from the storage array for `rd_addr` |
| rd_data | output | 8 | Registered read data |
| id_mode | output | 1 | Identification mode is active |
| prog_req | output | 1 | One-cycle byte program request |
| sec_erase_req | output | 1 | One-cycle sector erase request |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| op_addr | output | 19 | Target address of the request |
| op_data | output | 8 | Data byte of the program request |

## Verification
Every result of this block arrives exactly one clock after the edge that samples its cause. A request, `op_addr`/`op_data` and a change of `id_mode` all follow the write that completes the command. `rd_data` follows the `rd_addr` and mode that were present at that edge. The bench drives inputs on falling edges. A behavioural model updates on the rising edge from the same inputs, and all seven outputs are compared on the next falling edge. Each comparison therefore lands in the cycle where the registered result is due.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_BYTE_1  = 8'hAA;
  localparam logic [7:0] KEY_BYTE_2  = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_ID_ENTER = 8'h90;
  localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ER1,
    ST_ER2,
    ST_ER3
  } step_t;

endpackage

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
  import cmdseq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SECT_LSB = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  output logic          id_mode,
  output logic          prog_req,
  output logic          sec_erase_req,
  output logic          chip_erase_req,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);

  step_t         st_q, st_n;
  logic          id_q, id_n;
  logic          p_n, s_n, c_n;
  logic [AW-1:0] oa_n;
  logic [7:0]    od_n;
  logic          acc, hit_a, hit_b;

  assign acc   = wr_en && !busy;
  assign hit_a = (wr_addr[CMD_AW-1:0] == KEY_ADDR_A);
  assign hit_b = (wr_addr[CMD_AW-1:0] == KEY_ADDR_B);

  always_comb begin
    st_n = st_q;
    id_n = id_q;
    p_n  = 1'b0;
    s_n  = 1'b0;
    c_n  = 1'b0;
    oa_n = '0;
    od_n = '0;
    if (acc) begin
      // default outcome of an accepted write: back to idle, plain reads
      st_n = ST_IDLE;
      id_n = 1'b0;
      unique case (st_q)
        ST_IDLE: if (hit_a && wr_data == KEY_BYTE_1) begin
          st_n = ST_UNL1;
          id_n = id_q;
        end
        ST_UNL1: if (hit_b && wr_data == KEY_BYTE_2) begin
          st_n = ST_UNL2;
          id_n = id_q;
        end
        ST_UNL2: if (hit_a) begin
          if (wr_data == OP_PROGRAM) begin
            st_n = ST_PROG;
            id_n = id_q;
          end else if (wr_data == OP_ERASE) begin
            st_n = ST_ER1;
            id_n = id_q;
          end else if (wr_data == OP_ID_ENTER) begin
            id_n = 1'b1;
          end
        end
        ST_PROG: begin
          p_n  = 1'b1;
          oa_n = wr_addr;
          od_n = wr_data;
        end
        ST_ER1: if (hit_a && wr_data == KEY_BYTE_1) begin
          st_n = ST_ER2;
          id_n = id_q;
        end
        ST_ER2: if (hit_b && wr_data == KEY_BYTE_2) begin
          st_n = ST_ER3;
          id_n = id_q;
        end
        ST_ER3: begin
          if (hit_a && wr_data == OP_CHIP) begin
            c_n = 1'b1;
          end else if (wr_data == OP_SECTOR) begin
            s_n  = 1'b1;
            oa_n = {wr_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      id_q           <= 1'b0;
      prog_req       <= 1'b0;
      sec_erase_req  <= 1'b0;
      chip_erase_req <= 1'b0;
      op_addr        <= '0;
      op_data        <= '0;
    end else begin
      st_q           <= st_n;
      id_q           <= id_n;
      prog_req       <= p_n;
      sec_erase_req  <= s_n;
      chip_erase_req <= c_n;
      op_addr        <= oa_n;
      op_data        <= od_n;
    end
  end

  assign id_mode = id_q;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!id_q && st_q == ST_IDLE)); // R1
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (st_q == $past(st_q) && id_q == $past(id_q)
                         && !prog_req && !sec_erase_req && !chip_erase_req)); // R10
  AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (rst)
    (acc && st_q == ST_UNL2 && hit_a && wr_data == OP_ID_ENTER) |=> id_q); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (acc && st_q == ST_UNL1 && !(hit_b && wr_data == KEY_BYTE_2))
      |=> (st_q == ST_IDLE && !id_q && !prog_req)); // R9
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, sec_erase_req, chip_erase_req})); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (prog_req || sec_erase_req || chip_erase_req)
      |=> !(prog_req || sec_erase_req || chip_erase_req)); // R11

endmodule

// File: rtl/cmdseq_idmux.sv
module cmdseq_idmux
  import cmdseq_pkg::*;
#(
  parameter int         AW       = 19,
  parameter logic [7:0] MFR_CODE = 8'h7F,
  parameter logic [7:0] EXT_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hB7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_mode,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rd_data
);

  logic [CMD_AW-1:0] ofs;
  logic [7:0]        id_byte;

  assign ofs = rd_addr[CMD_AW-1:0];

  always_comb begin
    unique case (ofs)
      15'h0000: id_byte = MFR_CODE;
      15'h0003: id_byte = MFR_CODE;
      15'h0040: id_byte = EXT_CODE;
      15'h0001: id_byte = DEV_CODE;
      default:  id_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= id_mode ? id_byte : arr_data;
  end

  AST_RD_ARRAY: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> (rd_data == $past(arr_data))); // R7
  AST_RD_RESET: assert property (@(posedge clk) rst |=> (rd_data == 8'h00)); // R1

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top #(
  parameter int         AW       = 19,
  parameter int         SECT_LSB = 12,
  parameter logic [7:0] DEV_CODE = 8'hB7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rd_data,
  output logic          id_mode,
  output logic          prog_req,
  output logic          sec_erase_req,
  output logic          chip_erase_req,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);

  logic id_flag;

  cmdseq_fsm #(.AW(AW), .SECT_LSB(SECT_LSB)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .busy           (busy),
    .id_mode        (id_flag),
    .prog_req       (prog_req),
    .sec_erase_req  (sec_erase_req),
    .chip_erase_req (chip_erase_req),
    .op_addr        (op_addr),
    .op_data        (op_data)
  );

  cmdseq_idmux #(.AW(AW), .DEV_CODE(DEV_CODE)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .id_mode  (id_flag),
    .rd_addr  (rd_addr),
    .arr_data (arr_data),
    .rd_data  (rd_data)
  );

  assign id_mode = id_flag;

endmodule

// File: tb/cmdseq_top_test.sv
module cmdseq_top_test;

  localparam int CLK_P = 10;
  localparam int AW    = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    arr_data;
  logic [7:0]    rd_data;
  logic          id_mode, prog_req, sec_erase_req, chip_erase_req;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  always #(CLK_P/2) clk = ~clk;

  assign arr_data = rd_addr[7:0] ^ {1'b0, rd_addr[14:8]} ^ 8'h5A;

  cmdseq_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data),
    .id_mode(id_mode), .prog_req(prog_req), .sec_erase_req(sec_erase_req),
    .chip_erase_req(chip_erase_req), .op_addr(op_addr), .op_data(op_data)
  );

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    chk_on = 0;
  string tag = "R1";

  // reference model state
  logic [AW+7:0] q[$];
  bit            m_id = 0;
  logic [7:0]    e_rd = 0;
  bit            e_p = 0, e_s = 0, e_c = 0;
  logic [AW-1:0] e_oa = 0;
  logic [7:0]    e_od = 0;

  function automatic logic [7:0] ref_id(logic [AW-1:0] a);
    int o = int'(a[14:0]);
    if (o == 0 || o == 3) return 8'h7F;
    if (o == 'h40) return 8'h1F;
    if (o == 1) return 8'hB7;
    return 8'h00;
  endfunction

  function automatic int lo(int i);  return int'(q[i][22:8]); endfunction
  function automatic int dt(int i);  return int'(q[i][7:0]);  endfunction

  // 0 prefix, 1 invalid, 2 program, 3 sector, 4 chip, 5 id entry, 6 id exit
  function automatic int classify();
    int n = q.size();
    if (n == 1 && dt(0) == 'hF0) return 6;
    if (!(dt(0) == 'hAA && lo(0) == 'h5555)) return 1;
    if (n == 1) return 0;
    if (!(dt(1) == 'h55 && lo(1) == 'h2AAA)) return 1;
    if (n == 2) return 0;
    if (lo(2) != 'h5555) return 1;
    if (dt(2) == 'h90) return 5;
    if (dt(2) == 'hF0) return 6;
    if (dt(2) == 'hA0) return (n == 3) ? 0 : 2;
    if (dt(2) != 'h80) return 1;
    if (n == 3) return 0;
    if (!(dt(3) == 'hAA && lo(3) == 'h5555)) return 1;
    if (n == 4) return 0;
    if (!(dt(4) == 'h55 && lo(4) == 'h2AAA)) return 1;
    if (n == 5) return 0;
    if (dt(5) == 'h10 && lo(5) == 'h5555) return 4;
    if (dt(5) == 'h30) return 3;
    return 1;
  endfunction

  always @(posedge clk) begin
    int r;
    logic [AW+7:0] last;
    if (rst) begin
      q.delete();
      m_id = 0; e_rd = 0; e_p = 0; e_s = 0; e_c = 0; e_oa = 0; e_od = 0;
    end else begin
      e_rd = m_id ? ref_id(rd_addr) : arr_data;
      e_p = 0; e_s = 0; e_c = 0; e_oa = 0; e_od = 0;
      if (wr_en && !busy) begin
        q.push_back({wr_addr, wr_data});
        r = classify();
        if (r != 0) begin
          last = q[q.size()-1];
          q.delete();
          m_id = (r == 5);
          if (r == 2) begin e_p = 1; e_oa = last[AW+7:8]; e_od = last[7:0]; end
          if (r == 3) begin e_s = 1; e_oa = {last[AW+7:20], 12'h000}; end
          if (r == 4) e_c = 1;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("rd_data", 32'(rd_data), 32'(e_rd));
      chk("id_mode", 32'(id_mode), 32'(m_id));
      chk("prog_req", 32'(prog_req), 32'(e_p));
      chk("sec_erase_req", 32'(sec_erase_req), 32'(e_s));
      chk("chip_erase_req", 32'(chip_erase_req), 32'(e_c));
      chk("op_addr", 32'(op_addr), 32'(e_oa));
      chk("op_data", 32'(op_data), 32'(e_od));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, bit b = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = b;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 0; busy = 0; rd_addr = a;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  initial begin
    tag = "R1";
    repeat (2) @(negedge clk);
    chk_on = 1;
    rd(19'h00010);
    @(negedge clk); rst = 0;
    rd(19'h00011);
    rd(19'h00000);

    // program with don't-care high address bits on command writes
    tag = "R2";
    wr(19'h45555, 8'hAA); wr(19'h7AAAA, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h12345, 8'hC3);
    rd(19'h00100);
    tag = "R5";
    wr(19'h7D555, 8'hAA); wr(19'h0AAAA, 8'h55); wr(19'h3D555, 8'hA0);
    wr(19'h7FFFF, 8'h01);
    tag = "R11";
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00007, 8'h77);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00008, 8'h88);
    rd(19'h0);

    tag = "R3";
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h3ABCD, 8'h30);
    rd(19'h0);
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h45555, 8'h30);
    tag = "R4";
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h10);
    rd(19'h0);

    tag = "R6";
    unlock(); wr(19'h05555, 8'h90);
    tag = "R7";
    rd(19'h00000); rd(19'h00003); rd(19'h00040); rd(19'h00001);
    rd(19'h00002); rd(19'h48040); rd(19'h00041); rd(19'h00002);
    tag = "R8";
    wr(19'h01234, 8'hF0);
    rd(19'h00000); rd(19'h00001); rd(19'h00040);
    tag = "R6";
    unlock(); wr(19'h05555, 8'h90); rd(19'h00001);
    tag = "R8";
    unlock(); wr(19'h05555, 8'hF0);
    rd(19'h00001); rd(19'h00003);

    tag = "R9";
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h56);
    wr(19'h05555, 8'hA0); wr(19'h12345, 8'h99);
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00050, 8'h50);
    unlock(); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h54);
    wr(19'h05555, 8'h10);
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h00555, 8'h10);
    unlock(); wr(19'h05555, 8'h90); rd(19'h00040);
    wr(19'h00003, 8'h12); rd(19'h00040); rd(19'h00040);

    tag = "R10";
    wr(19'h05555, 8'hAA); wr(19'h00000, 8'h00, 1); wr(19'h02AAA, 8'h55);
    wr(19'h02AAA, 8'h55, 1); wr(19'h05555, 8'hA0); wr(19'h06666, 8'h66, 1);
    wr(19'h06666, 8'h6E);
    rd(19'h0);
    unlock(); wr(19'h05555, 8'h90);
    wr(19'h00000, 8'hF0, 1); wr(19'h00000, 8'h11, 1);
    rd(19'h00000); rd(19'h00001);

    tag = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(19'h00000); rd(19'h00040);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h01000, 8'h42);
    rd(19'h0); rd(19'h0);

    @(negedge clk);
    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule